// File: doc/BRIEF.md
# Microinstruction Parity Breakpoint Detector

This block sits beside the microinstruction register. Every time a control-store word is strobed in, it checks the word's odd parity as two independent halves. A half fails when its data bits, XORed with its effective parity bit, give zero. The effective parity bit of a half is its stored parity bit XORed with that half's marker bit.

The two marker bits form a small field that software can set on purpose. Writing 3 into it inverts both parity bits, so both halves fail together. The block reads a joint failure as a planted breakpoint. A failure in only one half is reported as a hardware fault. Writing 0 into the field restores clean parity.

A faulty word is never blocked: it is latched and executes like any other. The block then requests a stop at the second phase of that instruction, so the machine halts only after the instruction has completed. Two saturating counters keep the number of parity failures seen in each half. Software clears them with a clear strobe, used when detaching or when starting a program load. Reset also clears them.

Top module: `mir_parity_watch`

## Requirements
- R1: The low half is word bits 0 to 20 with par[0] and mark[0]. The high half is word bits 21 to 41 with par[1] and mark[1]. A half is bad when the XOR of its data bits and (par XOR mark) for that half is 0.
- R2: A load whose word has exactly one bad half sets err to 1 and brk to 0.
- R3: A load whose word has both halves bad sets brk to 1 and err to 0. On a word with correct stored parity, mark = 3 produces a break and mark = 0 produces no flag.
- R4: brk and err change only on the clock edge that samples load. They then hold their value until the next load. Reset clears both to 0.
- R5: Every load copies word into ir_q on that edge, whatever its parity.
- R6: After a load with at least one bad half, the first later phase2 that does not coincide with a load makes stop_req high for exactly one cycle, starting at the following edge. A phase2 that coincides with a load is ignored. A clean load never leads to stop_req.
- R7: cnt_lo increases by 1 on each load whose low half is bad. cnt_hi increases by 1 on each load whose high half is bad. Both counters count on a breakpoint load.
- R8: Each counter saturates at 65535 and does not wrap.
- R9: clr sets both counters to 0 at the next edge and wins over a count from a load in the same cycle. Reset also sets both counters to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that latches a control-store word |
| word | input | 42 | Microinstruction data bits |
| par | input | 2 | Stored odd-parity bits, bit 0 for the low half and bit 1 for the high half |
| mark | input | 2 | Parity-bad marker field; each set bit inverts the stored parity bit of its half |
| phase2 | input | 1 | Second phase of the executing instruction |
| clr | input | 1 | Counter clear strobe, used on detach or at load start |
| ir_q | output | 42 | Latched microinstruction |
| brk | output | 1 | Latched word was a breakpoint |
| err | output | 1 | Latched word had a single-half parity fault |
| stop_req | output | 1 | One-cycle stop request at the end of the faulty instruction |
| cnt_lo | output | 16 | Parity failures counted in the low half |
| cnt_hi | output | 16 | Parity failures counted in the high half |

## Verification
The latched word, flags and counters are all due one edge after the load or clear strobe. The bench drives each strobe at a falling edge and samples at the next falling edge, so no output is read on the edge where it changes. stop_req rises one edge after the qualifying phase2 and falls one edge later. It is therefore sampled in both of those half-periods, and also after a phase2 that coincided with a load. Saturation is reached by holding load high with a faulty word for more than 65535 consecutive edges, then reading the counter.

// File: rtl/mir_parity_watch.sv
module mir_parity_watch #(
  parameter int WORD_W = 42,
  parameter int LO_W   = 21,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        par,
  input  logic [1:0]        mark,
  input  logic              phase2,
  input  logic              clr,
  output logic [WORD_W-1:0] ir_q,
  output logic              brk,
  output logic              err,
  output logic              stop_req,
  output logic [CNT_W-1:0]  cnt_lo,
  output logic [CNT_W-1:0]  cnt_hi
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] bad;
  logic       armed;
  logic [CNT_W-1:0] cnt_q [2];

  assign bad[0] = ~^{word[LO_W-1:0], par[0] ^ mark[0]};
  assign bad[1] = ~^{word[WORD_W-1:LO_W], par[1] ^ mark[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q     <= '0;
      brk      <= 1'b0;
      err      <= 1'b0;
      armed    <= 1'b0;
      stop_req <= 1'b0;
    end else if (load) begin
      ir_q     <= word;
      brk      <= &bad;
      err      <= ^bad;
      armed    <= |bad;
      stop_req <= 1'b0;
    end else if (phase2 && armed) begin
      armed    <= 1'b0;
      stop_req <= 1'b1;
    end else begin
      stop_req <= 1'b0;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        cnt_q[h] <= '0;
      else if (load && bad[h] && cnt_q[h] != CNT_MAX)
        cnt_q[h] <= cnt_q[h] + 1'b1;
    end
  end

  assign cnt_lo = cnt_q[0];
  assign cnt_hi = cnt_q[1];
endmodule

module mir_parity_watch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             clr,
  input logic             brk,
  input logic             err,
  input logic             stop_req,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi
);
  a_r2_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk && err));

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> ($stable(brk) && $stable(err)));

  a_r6_stop_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (brk || err));

  a_r6_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  a_r7_step_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 1'b1));

  a_r7_step_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt_hi == $past(cnt_hi) || cnt_hi == $past(cnt_hi) + 1'b1));

  a_r7_idle_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(clr)) |-> $stable(cnt_lo));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_lo) == {CNT_W{1'b1}} && !$past(clr)) |-> cnt_lo == {CNT_W{1'b1}});

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt_lo == '0 && cnt_hi == '0));
endmodule

bind mir_parity_watch mir_parity_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .clr(clr), .brk(brk), .err(err),
  .stop_req(stop_req), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/mir_parity_watch_tb.sv
module mir_parity_watch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [41:0] word = '0;
  logic [1:0]  par = '0;
  logic [1:0]  mark = '0;
  logic        phase2 = 1'b0;
  logic        clr = 1'b0;
  logic [41:0] ir_q;
  logic        brk, err, stop_req;
  logic [15:0] cnt_lo, cnt_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mir_parity_watch u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word), .par(par), .mark(mark),
    .phase2(phase2), .clr(clr), .ir_q(ir_q), .brk(brk), .err(err),
    .stop_req(stop_req), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  function automatic logic [1:0] good_par(input logic [41:0] w);
    return {~^w[41:21], ~^w[20:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [41:0] w, input logic [1:0] p, input logic [1:0] m,
                         input logic ph, input logic cl);
    @(negedge clk);
    load = 1'b1; word = w; par = p; mark = m; phase2 = ph; clr = cl;
    @(negedge clk);
    load = 1'b0; phase2 = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_phase2();
    @(negedge clk);
    phase2 = 1'b1;
    @(negedge clk);
    phase2 = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset brk", brk, 0);
    chk("R4 reset err", err, 0);
    chk("R9 reset cnt_lo", cnt_lo, 0);
    chk("R9 reset cnt_hi", cnt_hi, 0);
    chk("R6 reset stop_req", stop_req, 0);
  endtask

  task automatic t_clean();
    logic [41:0] w = 42'h2A5_5A5A_1234;
    do_load(w, good_par(w), 2'b00, 1'b0, 1'b0);
    chk("R1 clean brk", brk, 0);
    chk("R1 clean err", err, 0);
    chk("R5 clean ir_q", ir_q, w);
    chk("R7 clean cnt_lo", cnt_lo, 0);
    pulse_phase2();
    chk("R6 clean no stop", stop_req, 0);
  endtask

  task automatic t_low_fault();
    logic [41:0] w = 42'h155_0F0F_00FF;
    logic [1:0] p = good_par(w);
    do_load(w ^ (42'h1 << 20), p, 2'b00, 1'b0, 1'b0);
    chk("R2 low fault err", err, 1);
    chk("R2 low fault brk", brk, 0);
    chk("R5 faulty word latched", ir_q, w ^ (42'h1 << 20));
    chk("R7 low count", cnt_lo, 1);
    chk("R1 bit20 not high", cnt_hi, 0);
    repeat (3) @(negedge clk);
    chk("R4 err held", err, 1);
    chk("R6 no stop before phase2", stop_req, 0);
    @(negedge clk);
    phase2 = 1'b1;
    @(negedge clk);
    phase2 = 1'b0;
    chk("R6 stop raised", stop_req, 1);
    @(negedge clk);
    chk("R6 stop one cycle", stop_req, 0);
    pulse_phase2();
    chk("R6 no second stop", stop_req, 0);
  endtask

  task automatic t_high_fault();
    logic [41:0] w = 42'h0;
    do_load(w ^ (42'h1 << 21), good_par(w), 2'b00, 1'b0, 1'b0);
    chk("R2 high fault err", err, 1);
    chk("R7 high count", cnt_hi, 1);
    chk("R1 bit21 not low", cnt_lo, 1);
    do_load(w, good_par(w) ^ 2'b10, 2'b00, 1'b0, 1'b0);
    chk("R1 stored par bit fault", err, 1);
    chk("R7 high count 2", cnt_hi, 2);
  endtask

  task automatic t_break();
    logic [41:0] w = 42'h3FF_FFFF_FFFE;
    do_load(w, good_par(w), 2'b11, 1'b0, 1'b0);
    chk("R3 marker break brk", brk, 1);
    chk("R3 marker break err", err, 0);
    chk("R7 break low", cnt_lo, 2);
    chk("R7 break high", cnt_hi, 3);
    pulse_phase2();
    chk("R6 break stop", stop_req, 1);
    do_load(w, good_par(w), 2'b00, 1'b0, 1'b0);
    chk("R3 marker cleared brk", brk, 0);
    chk("R3 marker cleared err", err, 0);
    do_load(w, good_par(w), 2'b01, 1'b0, 1'b0);
    chk("R2 single marker err", err, 1);
    chk("R2 single marker brk", brk, 0);
  endtask

  task automatic t_phase2_with_load();
    logic [41:0] w = 42'h0AB_CDEF_0123;
    do_load(w, good_par(w), 2'b11, 1'b1, 1'b0);
    chk("R6 coincident phase2 ignored", stop_req, 0);
    chk("R3 coincident brk", brk, 1);
    pulse_phase2();
    chk("R6 later phase2 stops", stop_req, 1);
  endtask

  task automatic t_clear();
    logic [41:0] w = 42'h0;
    pulse_clr();
    chk("R9 clr lo", cnt_lo, 0);
    chk("R9 clr hi", cnt_hi, 0);
    do_load(w, good_par(w), 2'b11, 1'b0, 1'b1);
    chk("R9 clr beats load lo", cnt_lo, 0);
    chk("R9 clr beats load hi", cnt_hi, 0);
    chk("R3 flags still set", brk, 1);
  endtask

  task automatic t_saturate();
    logic [41:0] w = 42'h1;
    @(negedge clk);
    load = 1'b1; word = w; par = good_par(w) ^ 2'b01; mark = 2'b00;
    repeat (65540) @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    chk("R8 lo saturated", cnt_lo, 16'hFFFF);
    chk("R8 hi untouched", cnt_hi, 0);
    do_load(w, good_par(w), 2'b11, 1'b0, 1'b0);
    chk("R8 lo stays max", cnt_lo, 16'hFFFF);
    chk("R7 hi after break", cnt_hi, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_low_fault();
    t_high_fault();
    t_break();
    t_phase2_with_load();
    t_clear();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule